// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock

This block is the clocked decision logic placed ahead of a high-side and a low-side gate driver in a half bridge. It receives a command for each switch, an active-low shutdown request and a supply-good flag for each side. It produces one drive enable per side. The logic blocks the two switches from conducting together. It gives the shutdown request and each side's supply flag the last word over that side's output. Short high-side command pulses are lengthened to a minimum width.

The high-side output reaches its driver across an isolation channel, and this block models that channel as a fixed pipeline of `HI_LAT` stages. The low-side path has no pulse lengthening. It carries its own delay line instead, sized so that a command on either input reaches its output in the same number of cycles. All five inputs are asynchronous and each passes through a two-flop synchronizer. The stretch length `MIN_PULSE` defaults to 5 cycles, which is 50 ns at 100 MHz.

Top module: `gate_interlock`

## Requirements
- R1: While `rstN` is low, and in the first cycles after it rises, `driveHi` and `driveLo` are both 0. The lengthening counter starts cleared.
- R2: `shutN` is active low. Two clock edges after it is sampled low, both outputs are 0, even while a high-side pulse is being lengthened.
- R3: A high `cmdHi` with a low `cmdLo` turns `driveHi` on. A high `cmdLo` with a low `cmdHi` turns `driveLo` on.
- R4: While both commands are high, the block treats both as off until one of them drops. `driveHi` and `driveLo` are never 1 in the same cycle.
- R5: Every level of the high-side request is held for at least `MIN_PULSE` cycles, whether it is high or low. A shorter input pulse comes out exactly `MIN_PULSE` cycles wide.
- R6: The low-side path does no lengthening. A `cmdLo` pulse of N cycles gives a `driveLo` pulse of N cycles, for any N of 1 or more.
- R7: From a command edge at an input to the matching edge at the output, both paths take `HI_LAT`+3 cycles. That total is two synchronizer stages, one decision register and the `HI_LAT` channel stages, which the low side matches with `HI_LAT`+1 delay stages.
- R8: Two clock edges after `supplyOkHi` is sampled low, `driveHi` is 0. Two edges after `supplyOkLo` is sampled low, `driveLo` is 0. Each flag affects only its own side.
- R9: A high-side pulse being lengthened ends at once when the low-side request alone becomes active. The high-side request then stays low for `MIN_PULSE` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdHi | input | 1 | High-side switch command (asynchronous) |
| cmdLo | input | 1 | Low-side switch command (asynchronous) |
| shutN | input | 1 | Shutdown request, active low (asynchronous) |
| supplyOkHi | input | 1 | High-side supply good flag (asynchronous) |
| supplyOkLo | input | 1 | Low-side supply good flag (asynchronous) |
| driveHi | output | 1 | High-side drive enable |
| driveLo | output | 1 | Low-side drive enable |

## Verification
Pulse lengthening and the low-side takeover can act in the same cycle: a one-cycle high-side command starts a stretch, and a low-side command arrives two cycles later. The bench checks that `driveHi` lasts exactly two cycles rather than `MIN_PULSE`, and that `driveLo` rises in the cycle `driveHi` falls, with neither a gap nor an overlap. Long random stretches toggle the commands, the shutdown and the supply flags on every cycle. A cycle-level model in the bench judges each output in every cycle.

// File: rtl/gate_pkg.sv
package gate_pkg;

  // Synchronized and decided strobes passed from control to datapath
  typedef struct packed {
    logic hiLevel;     // registered, stretched high-side request
    logic loLevel;     // interlocked low-side request (undelayed)
    logic shutOk;      // synchronized shutdown input, 1 = run
    logic hiSupplyOk;  // synchronized high-side supply flag
    logic loSupplyOk;  // synchronized low-side supply flag
  } gateStrobe_t;

  localparam int SYNC_BITS = 5;

endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageA;
  logic [WIDTH-1:0] stageB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA <= '0;
      stageB <= '0;
    end else begin
      stageA <= asyncIn;
      stageB <= stageA;
    end
  end

  assign syncOut = stageB;

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import gate_pkg::*;
#(
  parameter int MIN_PULSE = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdHi,
  input  logic        cmdLo,
  input  logic        shutN,
  input  logic        supplyOkHi,
  input  logic        supplyOkLo,
  output gateStrobe_t strobe
);

  localparam int CNT_W = (MIN_PULSE > 1) ? $clog2(MIN_PULSE + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MIN_PULSE - 1);
  localparam logic [CNT_W-1:0] AGE_MAX  = CNT_W'(MIN_PULSE);

  logic [SYNC_BITS-1:0] syncBus;
  logic                 hiSync, loSync;
  logic                 hiReq, loReq;
  logic                 hiLvl, hiLvlNext;
  logic [CNT_W-1:0]     holdCnt, holdCntNext;
  logic [CNT_W-1:0]     runAge;

  gate_sync #(.WIDTH(SYNC_BITS)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({supplyOkLo, supplyOkHi, shutN, cmdLo, cmdHi}),
    .syncOut (syncBus)
  );

  assign hiSync = syncBus[0];
  assign loSync = syncBus[1];

  // Interlock: a request survives only when the other one is absent
  assign hiReq = hiSync & ~loSync;
  assign loReq = loSync & ~hiSync;

  // High-side stretcher: every level is held for MIN_PULSE cycles,
  // except that a lone low-side request aborts a high stretch.
  always_comb begin
    hiLvlNext   = hiLvl;
    holdCntNext = holdCnt;
    if (holdCnt != '0) begin
      if (hiLvl && loReq) begin
        hiLvlNext   = 1'b0;
        holdCntNext = CNT_LOAD;
      end else begin
        holdCntNext = holdCnt - 1'b1;
      end
    end else if (hiReq != hiLvl) begin
      hiLvlNext   = hiReq;
      holdCntNext = CNT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLvl   <= 1'b0;
      holdCnt <= '0;
    end else begin
      hiLvl   <= hiLvlNext;
      holdCnt <= holdCntNext;
    end
  end

  // Age of the current high-side level, used only by the check below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runAge <= AGE_MAX;
    end else if (hiLvlNext != hiLvl) begin
      runAge <= CNT_W'(1);
    end else if (runAge < AGE_MAX) begin
      runAge <= runAge + 1'b1;
    end
  end

  always_comb begin
    strobe.hiLevel    = hiLvl;
    strobe.loLevel    = loReq;
    strobe.shutOk     = syncBus[2];
    strobe.hiSupplyOk = syncBus[3];
    strobe.loSupplyOk = syncBus[4];
  end

  AST_HI_MIN_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (hiLvl != $past(hiLvl)) && !$past(loReq) |-> $past(runAge) >= AGE_MAX)
    else $error("high-side level shorter than minimum"); // R5

  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    loReq |=> !hiLvl)
    else $error("high stretch survived a lone low request"); // R9

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import gate_pkg::*;
#(
  parameter int HI_LAT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  output logic        driveHi,
  output logic        driveLo
);

  localparam int LO_DEPTH = HI_LAT + 1;

  logic hiTail;
  logic loTail;
  logic [LO_DEPTH-1:0] loPipe;

  // Isolated channel model on the high side
  generate
    if (HI_LAT == 0) begin : gHiDirect
      assign hiTail = strobe.hiLevel;
    end else begin : gHiPipe
      logic [HI_LAT-1:0] hiPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hiPipe <= '0;
        else       hiPipe <= (hiPipe << 1) | HI_LAT'(strobe.hiLevel);
      end
      assign hiTail = hiPipe[HI_LAT-1];
    end
  endgenerate

  // Matching delay on the low side: covers the stretch register too
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loPipe <= '0;
    else       loPipe <= (loPipe << 1) | LO_DEPTH'(strobe.loLevel);
  end
  assign loTail = loPipe[LO_DEPTH-1];

  // Overrides act after all delay stages
  assign driveHi = hiTail & strobe.shutOk & strobe.hiSupplyOk;
  assign driveLo = loTail & strobe.shutOk & strobe.loSupplyOk;

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    !(driveHi && driveLo))
    else $error("both drive enables active"); // R4

endmodule

// File: rtl/gate_interlock.sv
module gate_interlock
  import gate_pkg::*;
#(
  parameter int MIN_PULSE = 5,
  parameter int HI_LAT    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdHi,
  input  logic cmdLo,
  input  logic shutN,
  input  logic supplyOkHi,
  input  logic supplyOkLo,
  output logic driveHi,
  output logic driveLo
);

  gateStrobe_t strobe;

  gate_ctrl #(.MIN_PULSE(MIN_PULSE)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdHi      (cmdHi),
    .cmdLo      (cmdLo),
    .shutN      (shutN),
    .supplyOkHi (supplyOkHi),
    .supplyOkLo (supplyOkLo),
    .strobe     (strobe)
  );

  gate_datapath #(.HI_LAT(HI_LAT)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .driveHi (driveHi),
    .driveLo (driveLo)
  );

  AST_SHUT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(shutN, 2) |-> !driveHi && !driveLo)
    else $error("output active during shutdown"); // R2

  AST_SUPPLY_HI: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyOkHi, 2) |-> !driveHi)
    else $error("high side active without supply"); // R8

  AST_SUPPLY_LO: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyOkLo, 2) |-> !driveLo)
    else $error("low side active without supply"); // R8

endmodule

// File: tb/tb_gate_interlock.sv
module tb_gate_interlock;

  localparam int MINP = 5;
  localparam int HL   = 2;
  localparam int LOD  = HL + 1;
  localparam int LAT  = HL + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdHi = 1'b0, cmdLo = 1'b0, shutN = 1'b1;
  logic okHi = 1'b0, okLo = 1'b0;
  logic driveHi, driveLo;

  always #2 clk = ~clk;

  gate_interlock #(.MIN_PULSE(MINP), .HI_LAT(HL)) dut (
    .clk(clk), .rstN(rstN), .cmdHi(cmdHi), .cmdLo(cmdLo), .shutN(shutN),
    .supplyOkHi(okHi), .supplyOkLo(okLo), .driveHi(driveHi), .driveLo(driveLo)
  );

  int errors = 0;
  int checks = 0;
  string phaseTag = "R3";
  bit cmpEn = 1'b0;
  bit reported = 1'b0;

  task automatic checkInt(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Cycle-level reference built from the requirements
  logic [4:0] ms1 = '0, ms2 = '0;   // {okLo, okHi, shutN, cmdLo, cmdHi}
  logic mHiLvl = 1'b0;
  int mCnt = 0;
  logic [HL-1:0] mHiP = '0;
  logic [LOD-1:0] mLoP = '0;
  logic hr, lr, expHi, expLo;

  always @(posedge clk) begin
    if (!rstN) begin
      ms1 = '0; ms2 = '0; mHiLvl = 1'b0; mCnt = 0; mHiP = '0; mLoP = '0;
    end else begin
      hr = ms2[0] & ~ms2[1];
      lr = ms2[1] & ~ms2[0];
      mLoP = {mLoP[LOD-2:0], lr};
      mHiP = {mHiP[HL-2:0], mHiLvl};
      if (mCnt > 0) begin
        if (mHiLvl && lr) begin mHiLvl = 1'b0; mCnt = MINP - 1; end
        else mCnt = mCnt - 1;
      end else if (hr != mHiLvl) begin
        mHiLvl = hr; mCnt = MINP - 1;
      end
      ms2 = ms1;
      ms1 = {okLo, okHi, shutN, cmdLo, cmdHi};
    end
    expHi = mHiP[HL-1] & ms2[2] & ms2[3];
    expLo = mLoP[LOD-1] & ms2[2] & ms2[4];
  end

  always @(negedge clk) begin
    if (cmpEn && rstN) begin
      checkInt(phaseTag, "driveHi", int'(driveHi), int'(expHi));
      checkInt(phaseTag, "driveLo", int'(driveLo), int'(expLo));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  logic [15:0] lfsr = 16'hACE1;
  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    int cntA, cntB;
    // R1: outputs off during reset with active-looking inputs
    cmdHi = 1'b1; okHi = 1'b1; okLo = 1'b1; shutN = 1'b1;
    repeat (4) @(negedge clk);
    checkInt("R1", "driveHi in reset", int'(driveHi), 0);
    checkInt("R1", "driveLo in reset", int'(driveLo), 0);
    cmdHi = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkInt("R1", "driveHi after reset", int'(driveHi), 0);
    checkInt("R1", "driveLo after reset", int'(driveLo), 0);
    cmpEn = 1'b1;
    repeat (10) @(negedge clk);

    // R7: both paths have the same latency
    phaseTag = "R7";
    cmdHi = 1'b1;
    repeat (LAT - 1) @(negedge clk);
    checkInt("R7", "driveHi before latency", int'(driveHi), 0);
    @(negedge clk);
    checkInt("R7", "driveHi at latency", int'(driveHi), 1);
    cmdHi = 1'b0;
    repeat (20) @(negedge clk);
    cmdLo = 1'b1;
    repeat (LAT - 1) @(negedge clk);
    checkInt("R7", "driveLo before latency", int'(driveLo), 0);
    @(negedge clk);
    checkInt("R7", "driveLo at latency", int'(driveLo), 1);
    cmdLo = 1'b0;
    repeat (20) @(negedge clk);

    // R5: high pulses of every short width
    phaseTag = "R5";
    for (int w = 1; w <= 8; w++) begin
      cntA = 0;
      for (int k = 0; k < 40; k++) begin
        cmdHi = (k < w);
        @(negedge clk);
        cntA += int'(driveHi);
      end
      checkInt("R5", $sformatf("high pulse width w=%0d", w), cntA, (w < MINP) ? MINP : w);
    end
    // R5: low gaps in a high command
    for (int g = 1; g <= 8; g++) begin
      cmdHi = 1'b1;
      repeat (20) @(negedge clk);
      cntA = 0;
      for (int k = 0; k < 40; k++) begin
        cmdHi = !(k < g);
        @(negedge clk);
        cntA += int'(!driveHi);
      end
      checkInt("R5", $sformatf("low gap width g=%0d", g), cntA, (g < MINP) ? MINP : g);
    end
    cmdHi = 1'b0;
    repeat (20) @(negedge clk);

    // R6: low pulses pass unchanged
    phaseTag = "R6";
    for (int w = 1; w <= 8; w++) begin
      cntA = 0;
      for (int k = 0; k < 30; k++) begin
        cmdLo = (k < w);
        @(negedge clk);
        cntA += int'(driveLo);
      end
      checkInt("R6", $sformatf("low-side pulse w=%0d", w), cntA, w);
    end

    // R9: low request cuts a high stretch short
    phaseTag = "R9";
    cntA = 0; cntB = 0;
    for (int k = 0; k < 40; k++) begin
      cmdHi = (k == 0);
      cmdLo = (k >= 2 && k < 20);
      @(negedge clk);
      cntA += int'(driveHi);
      cntB += int'(driveLo);
    end
    checkInt("R9", "aborted high pulse width", cntA, 2);
    checkInt("R9", "low pulse after abort", cntB, 18);

    // R4: both commands high turns both off
    phaseTag = "R4";
    cmdHi = 1'b1;
    repeat (20) @(negedge clk);
    cntA = 0; cntB = 0;
    for (int k = 0; k < 40; k++) begin
      cmdLo = (k >= 10 && k < 20);
      @(negedge clk);
      cntA += int'(!driveHi);
      cntB += int'(driveLo);
    end
    checkInt("R4", "driveHi off cycles while both high", cntA, 10);
    checkInt("R4", "driveLo cycles while both high", cntB, 0);
    cmdHi = 1'b0;
    repeat (20) @(negedge clk);

    // R3: random commands, supplies and shutdown steady
    phaseTag = "R3";
    for (int c = 0; c < 1500; c++) begin
      stepLfsr();
      cmdHi = lfsr[0];
      cmdLo = lfsr[5] & lfsr[7];
      @(negedge clk);
    end
    // R2: random shutdown during random commands
    phaseTag = "R2";
    for (int c = 0; c < 1500; c++) begin
      stepLfsr();
      cmdHi = lfsr[0] & lfsr[6];
      cmdLo = lfsr[5] & ~lfsr[6];
      shutN = ~(lfsr[3] & lfsr[9] & lfsr[11]);
      @(negedge clk);
    end
    shutN = 1'b1;
    // R8: random supply flags
    phaseTag = "R8";
    for (int c = 0; c < 1500; c++) begin
      stepLfsr();
      cmdHi = lfsr[0] & lfsr[6];
      cmdLo = lfsr[5] & ~lfsr[6];
      okHi = ~(lfsr[2] & lfsr[8]);
      okLo = ~(lfsr[4] & lfsr[14]);
      @(negedge clk);
    end
    okHi = 1'b1; okLo = 1'b1; cmdHi = 1'b0; cmdLo = 1'b0;
    repeat (20) @(negedge clk);
    report();
  end

endmodule